// File: doc/BRIEF.md
# Phase Offset Build-Out Corrector

This block sits between the phase detector inputs and the loop filter of a digital PLL. It removes the phase step that the output would otherwise take when the loop moves to a different reference, or when it leaves holdover. On such an event it captures the phase difference between the newly used reference and the loop feedback, and stores it as an offset. From then on the offset is subtracted from the reference phase. The loop therefore sees a virtual reference that starts exactly in phase with its own feedback, and the phase error it receives right after the event is close to zero.

An active-low clear releases the stored offset. The block then slews the offset back to zero in steps no larger than a programmable slope limit. Steps are taken only on update ticks, and they always run the shorter way around the phase circle. As the offset shrinks, the output realigns with the real reference. If the clear is held low, the offset stays at zero and capture events are ignored, so the error always tracks the selected reference. Phases are unsigned counters modulo 2^PHASE_W, and the error and offset are two's complement values of PHASE_W bits.

Top module: `pbo_corrector`

## Requirements
- R1: While reset is asserted and after its release, the stored offset is zero, so phase_err_o equals ref_phase_i minus fb_phase_i, taken modulo 2^PHASE_W and read as a signed PHASE_W-bit value.
- R2: A high ref_switch_i sampled at a rising clock edge, with no accepted clear, loads the offset with (ref_phase_i - fb_phase_i) mod 2^PHASE_W. With unchanged inputs, phase_err_o then reads zero.
- R3: A high hold_exit_i sampled with hold_recap_en_i high, and with no accepted clear, loads the offset in the same way as R2.
- R4: A high hold_exit_i sampled with hold_recap_en_i low leaves the offset unchanged.
- R5: phase_err_o is the combinational value (ref_phase_i - fb_phase_i - offset) mod 2^PHASE_W, read as a signed value in the range -2^(PHASE_W-1) to 2^(PHASE_W-1)-1.
- R6: clr_ni passes through SYNC_STAGES flops and counts as accepted only when CLR_MIN_LOW consecutive synchronized samples are low. With the defaults, a low level sampled at edges n-2 and n-3 is acted on at edge n+1. A low pulse covering a single edge has no effect.
- R7: While the clear is accepted or a decay is in progress, each edge with tick_i high moves the offset toward zero by min(|offset|, slope_lim_i). This is the shorter direction, and an offset of -2^(PHASE_W-1) moves upward. Edges without tick_i do not change the offset.
- R8: A decay that has started continues after clr_ni returns high, until the offset reaches zero. A capture event that arrives with no accepted clear ends the decay and loads a new offset.
- R9: While the clear is accepted, capture events are ignored. With the clear held low, the offset stays zero and phase_err_o tracks ref_phase_i minus fb_phase_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_phase_i | input | PHASE_W | Reference phase counter |
| fb_phase_i | input | PHASE_W | Feedback phase counter |
| ref_switch_i | input | 1 | Reference has changed (capture event) |
| hold_exit_i | input | 1 | Loop is leaving holdover |
| hold_recap_en_i | input | 1 | Allow capture on holdover exit |
| clr_ni | input | 1 | Active-low offset clear, asynchronous |
| tick_i | input | 1 | Decay update strobe |
| slope_lim_i | input | PHASE_W-1 | Largest offset change per tick |
| phase_err_o | output | PHASE_W | Signed corrected phase error |

## Verification
The hardest states to reach are a decay that outlives its clear and a capture that cuts a decay short. Both need a clear long enough to pass the synchronizer and the low-level filter. After that, a precise mix of tick edges, a rising clear and a capture strobe has to land while the offset is still non-zero. The stimulus loads large offsets of both signs, including exactly half a period, with slope limits of 0, 1, 5 and the maximum. It toggles tick_i on alternate cycles so that hold cycles and step cycles interleave. It fires capture strobes at chosen points inside the decay. A behavioural model predicts the accepted clear from a history queue of sampled clr_ni values, and the error is compared on every cycle.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
  typedef enum logic [1:0] {
    OFF_HOLD    = 2'd0,
    OFF_CAPTURE = 2'd1,
    OFF_SLEW    = 2'd2
  } off_act_e;
endpackage

// File: rtl/pbo_clr_filter.sv
module pbo_clr_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_ni,
  output logic clr_act_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [MIN_LOW-1:0]     hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], clr_ni};
  end

  generate
    if (MIN_LOW == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '1;
        else         hist_q <= sync_q[SYNC_STAGES-1];
      end
    end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '1;
        else         hist_q <= {hist_q[MIN_LOW-2:0], sync_q[SYNC_STAGES-1]};
      end
    end
  endgenerate

  assign clr_act_o = ~|hist_q;
endmodule

// File: rtl/pbo_event_ctl.sv
module pbo_event_ctl
  import pbo_pkg::*;
(
  input  logic     ref_switch_i,
  input  logic     hold_exit_i,
  input  logic     hold_recap_en_i,
  input  logic     clr_act_i,
  input  logic     bleed_i,
  input  logic     tick_i,
  output off_act_e act_o
);
  logic capture;
  assign capture = ref_switch_i | (hold_exit_i & hold_recap_en_i);

  always_comb begin
    act_o = OFF_HOLD;
    if (clr_act_i) begin
      if (tick_i) act_o = OFF_SLEW;
    end else if (capture) begin
      act_o = OFF_CAPTURE;
    end else if (bleed_i && tick_i) begin
      act_o = OFF_SLEW;
    end
  end
endmodule

// File: rtl/pbo_offset_reg.sv
module pbo_offset_reg
  import pbo_pkg::*;
#(
  parameter int W  = 8,
  parameter int SW = W - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  off_act_e      act_i,
  input  logic          bleed_set_i,
  input  logic [W-1:0]  ref_phase_i,
  input  logic [W-1:0]  fb_phase_i,
  input  logic [SW-1:0] slope_lim_i,
  output logic [W-1:0]  off_o,
  output logic          bleed_o
);
  logic [W-1:0] off_q, off_nxt, cap_val, mag, slope_ext, step, slewed;
  logic         bleed_q, bleed_nxt;

  assign cap_val   = ref_phase_i - fb_phase_i;
  assign mag       = off_q[W-1] ? (~off_q + 1'b1) : off_q;
  assign slope_ext = {{(W-SW){1'b0}}, slope_lim_i};
  assign step      = (mag < slope_ext) ? mag : slope_ext;
  // move toward zero: shortest way round the circle
  assign slewed    = off_q[W-1] ? (off_q + step) : (off_q - step);

  always_comb begin
    unique case (act_i)
      OFF_CAPTURE: off_nxt = cap_val;
      OFF_SLEW:    off_nxt = slewed;
      default:     off_nxt = off_q;
    endcase
    bleed_nxt = (bleed_q | bleed_set_i) & (act_i != OFF_CAPTURE) & (off_nxt != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q   <= '0;
      bleed_q <= 1'b0;
    end else begin
      off_q   <= off_nxt;
      bleed_q <= bleed_nxt;
    end
  end

  assign off_o   = off_q;
  assign bleed_o = bleed_q;
endmodule

// File: rtl/pbo_err_calc.sv
module pbo_err_calc #(
  parameter int W = 8
) (
  input  logic [W-1:0]        ref_phase_i,
  input  logic [W-1:0]        fb_phase_i,
  input  logic [W-1:0]        off_i,
  output logic signed [W-1:0] err_o
);
  logic [W-1:0] virt_ref;
  assign virt_ref = ref_phase_i - off_i;
  assign err_o    = $signed(virt_ref - fb_phase_i);
endmodule

// File: rtl/pbo_corrector.sv
module pbo_corrector
  import pbo_pkg::*;
#(
  parameter int PHASE_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CLR_MIN_LOW = 2,
  localparam int SLOPE_W    = PHASE_W - 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [PHASE_W-1:0]        ref_phase_i,
  input  logic [PHASE_W-1:0]        fb_phase_i,
  input  logic                      ref_switch_i,
  input  logic                      hold_exit_i,
  input  logic                      hold_recap_en_i,
  input  logic                      clr_ni,
  input  logic                      tick_i,
  input  logic [SLOPE_W-1:0]        slope_lim_i,
  output logic signed [PHASE_W-1:0] phase_err_o
);
  logic               clr_act;
  logic               bleed_q;
  logic [PHASE_W-1:0] off_q;
  off_act_e           act;

  pbo_clr_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(CLR_MIN_LOW)) u_clr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .clr_act_o(clr_act)
  );

  pbo_event_ctl u_ctl (
    .ref_switch_i(ref_switch_i), .hold_exit_i(hold_exit_i),
    .hold_recap_en_i(hold_recap_en_i), .clr_act_i(clr_act),
    .bleed_i(bleed_q), .tick_i(tick_i), .act_o(act)
  );

  pbo_offset_reg #(.W(PHASE_W), .SW(SLOPE_W)) u_off (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .bleed_set_i(clr_act),
    .ref_phase_i(ref_phase_i), .fb_phase_i(fb_phase_i),
    .slope_lim_i(slope_lim_i), .off_o(off_q), .bleed_o(bleed_q)
  );

  pbo_err_calc #(.W(PHASE_W)) u_err (
    .ref_phase_i(ref_phase_i), .fb_phase_i(fb_phase_i),
    .off_i(off_q), .err_o(phase_err_o)
  );
endmodule

// File: rtl/pbo_corrector_chk.sv
module pbo_corrector_chk #(
  parameter int W  = 8,
  parameter int SW = W - 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [W-1:0]  ref_phase_i,
  input logic [W-1:0]  fb_phase_i,
  input logic          ref_switch_i,
  input logic          hold_exit_i,
  input logic          hold_recap_en_i,
  input logic          tick_i,
  input logic [SW-1:0] slope_lim_i,
  input logic          clr_act,
  input logic          bleed,
  input logic [W-1:0]  off
);
  logic [W-1:0] diff, mag;
  logic         cap;
  assign diff = ref_phase_i - fb_phase_i;
  assign mag  = off[W-1] ? (~off + 1'b1) : off;
  assign cap  = ref_switch_i | (hold_exit_i & hold_recap_en_i);

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_switch_i && !clr_act) |=> (off == $past(diff)));

  p_recap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_exit_i && hold_recap_en_i && !clr_act) |=> (off == $past(diff)));

  p_no_recap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_exit_i && !hold_recap_en_i && !ref_switch_i && !clr_act && !bleed) |=> $stable(off));

  p_slope_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (clr_act || (bleed && !cap))) |=>
      ((mag <= $past(mag)) && (($past(mag) - mag) <= {1'b0, $past(slope_lim_i)})
       && ((off == '0) || (off[W-1] == $past(off[W-1])))));

  p_no_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && (clr_act || !cap)) |=> $stable(off));

  p_zero_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_act && (off == '0)) |=> (off == '0));
endmodule

bind pbo_corrector pbo_corrector_chk #(.W(PHASE_W), .SW(SLOPE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ref_phase_i(ref_phase_i), .fb_phase_i(fb_phase_i),
  .ref_switch_i(ref_switch_i), .hold_exit_i(hold_exit_i),
  .hold_recap_en_i(hold_recap_en_i), .tick_i(tick_i), .slope_lim_i(slope_lim_i),
  .clr_act(clr_act), .bleed(bleed_q), .off(off_q)
);

// File: tb/sim_pbo_corrector.sv
module sim_pbo_corrector;
  localparam int W = 8;
  localparam int PER = 1 << W;
  localparam int SYNC = 2;
  localparam int MINL = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [W-1:0] ref_ph = '0, fb_ph = '0;
  logic sw = 1'b0, hx = 1'b0, en = 1'b0, clr_n = 1'b1, tick = 1'b0;
  logic [W-2:0] slope = '0;
  logic signed [W-1:0] err;

  int total = 0, fails = 0;
  bit done = 0;
  string req = "R1";

  always #10 clk = ~clk;

  pbo_corrector u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_phase_i(ref_ph), .fb_phase_i(fb_ph),
    .ref_switch_i(sw), .hold_exit_i(hx), .hold_recap_en_i(en), .clr_ni(clr_n),
    .tick_i(tick), .slope_lim_i(slope), .phase_err_o(err)
  );

  function automatic int wrapi(int x);
    int m = ((x % PER) + PER) % PER;
    return (m >= PER / 2) ? m - PER : m;
  endfunction

  // behavioural model
  int moff = 0;
  bit mbleed = 0;
  bit cq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      moff = 0; mbleed = 0; cq = {};
      for (int k = 0; k < SYNC + MINL; k++) cq.push_front(1'b1);
    end else begin
      bit act, cap, bl;
      int st;
      act = 1;
      for (int k = 0; k < MINL; k++) if (cq[SYNC + k]) act = 0;
      cap = sw || (hx && en);
      bl  = act || mbleed;
      if (!act && cap) begin
        moff = wrapi(int'(ref_ph) - int'(fb_ph));
        mbleed = 0;
      end else begin
        if (bl && tick) begin
          st = (moff < 0) ? -moff : moff;
          if (st > int'(slope)) st = int'(slope);
          moff = (moff < 0) ? moff + st : moff - st;
        end
        mbleed = bl && (moff != 0);
      end
      cq.push_front(clr_n);
      if (cq.size() > 16) void'(cq.pop_back());
    end
  end

  task automatic chk();
    int exp_v = wrapi(int'(ref_ph) - int'(fb_ph) - moff);
    total++;
    if (int'(err) != exp_v) begin
      fails++;
      $display("FAIL %s: phase_err_o=%0d expected %0d", req, int'(err), exp_v);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin
      @(posedge clk); #5;
      chk();
    end
  endtask

  task automatic capture_at(int r, int f);
    ref_ph = W'(r); fb_ph = W'(f); sw = 1; cyc(1); sw = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    // R1 reset state
    ref_ph = 10; fb_ph = 3; slope = 4;
    #1 rst_n = 0;
    #2 chk();
    @(posedge clk); #5 chk();
    rst_n = 1;
    cyc(2);

    // R5 signed wrap of error
    req = "R5";
    ref_ph = 250; fb_ph = 5;   cyc(1);
    ref_ph = 5;   fb_ph = 250; cyc(1);
    ref_ph = 128; fb_ph = 0;   cyc(1);
    ref_ph = 0;   fb_ph = 128; cyc(1);
    ref_ph = 77;  fb_ph = 77;  cyc(1);

    // R2 capture on reference switch
    req = "R2";
    capture_at(100, 20);
    cyc(1);
    ref_ph = 105; cyc(1);
    fb_ph = 30;   cyc(1);

    // R4 holdover exit with recapture disabled
    req = "R4";
    ref_ph = 40; fb_ph = 200;
    hx = 1; en = 0; cyc(1); hx = 0;
    cyc(2);

    // R3 holdover exit with recapture enabled
    req = "R3";
    hx = 1; en = 1; cyc(1); hx = 0; en = 0;
    cyc(2);
    ref_ph = 45; cyc(1);

    // R6 short clear pulse ignored
    req = "R6";
    capture_at(200, 0);
    tick = 1; slope = 5;
    clr_n = 0; cyc(1); clr_n = 1;
    cyc(6);
    tick = 0;

    // R7 decay with alternating ticks, negative offset
    req = "R7";
    clr_n = 0; cyc(3); clr_n = 1;
    for (int i = 0; i < 8; i++) begin tick = i[0]; cyc(1); end
    // R8 decay continues after clear release
    req = "R8";
    for (int i = 0; i < 24; i++) begin tick = i[0]; cyc(1); end
    tick = 0;

    // R7 positive offset, slope 1, then slope 0 freezes
    req = "R7";
    capture_at(127, 0);
    slope = 1; clr_n = 0; cyc(3); clr_n = 1;
    tick = 1; cyc(4);
    slope = 0; cyc(3);
    slope = 127; cyc(2);
    tick = 0;

    // R7 half-period offset moves upward
    capture_at(128, 0);
    slope = 3; clr_n = 0; cyc(3); clr_n = 1;
    tick = 1; cyc(4); tick = 0; cyc(1);

    // R8 capture ends a decay in progress
    req = "R8";
    capture_at(90, 10);
    slope = 1; clr_n = 0; cyc(3); clr_n = 1;
    tick = 1; cyc(5);
    capture_at(60, 250);
    cyc(6);
    tick = 0;

    // R9 clear held low: captures ignored, error tracks reference
    req = "R9";
    clr_n = 0; slope = 127; tick = 1; cyc(4); tick = 0;
    capture_at(33, 3);
    cyc(1);
    hx = 1; en = 1; ref_ph = 70; cyc(1); hx = 0; en = 0;
    ref_ph = 180; fb_ph = 20; cyc(2);
    clr_n = 1; cyc(4);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule